// File: doc/BRIEF.md
# Indirect-Branch Retirement Trainer

This block trains prediction state after an indirect branch retires, away from the fetch path. The prediction side treats one indirect branch as a chain of virtual conditional branches. Iteration i of that chain uses a virtual PC, which is the real PC mixed with a per-iteration hash, and a virtual history, which is the prediction-time global history shifted left by i. The trainer walks the same chain. It issues one direction-predictor update per virtual branch and then makes one write to the target buffer. That write either raises the use count of the entry holding the correct target or installs the correct target over a victim entry.

A retirement request carries the real PC, the global history captured at prediction time, the resolved target, the iteration that produced the prediction, and a flag that says whether the prediction was correct. After a correct prediction the final iteration is already known, so the walk goes straight to training. After a misprediction the block first scans the target buffer one iteration per cycle. It looks for the correct target, and while it scans it tracks the best slot to replace. The storage of both predictors lives outside the block. The buffer answers a read combinationally in the same cycle.

Top module: `vbr_trainer`

## Requirements
- R1: For iteration i, the virtual PC equals the real PC XOR the low PC_W bits of i × 0x9E3779B97F4A7C15 (64-bit product). The virtual history equals the captured history shifted left by i bits, with zeros filled in. Every buffer read and every predictor update uses these values.
- R2: Training issues exactly one predictor update per cycle for iterations 0 through k in order, where k is the final iteration. Iterations below k are marked not-taken (dp_upd_taken=0). Iteration k is marked taken (dp_upd_taken=1), and busy falls in the cycle after it.
- R3: When the request has rt_hit=1, k equals rt_iter and no scan takes place: the first training update appears in the first cycle after the request is accepted. In the cycle of iteration k the buffer is written at that virtual PC, with the resolved target and the entry's count incremented by one.
- R4: When the request has rt_hit=0, the scan reads iterations in order. The first iteration whose entry is valid and holds the resolved target becomes k, and that entry's count is written back incremented by one.
- R5: An incremented use count saturates at its all-ones value and never wraps to zero.
- R6: When no scanned iteration matches, the resolved target is installed with count 1 at the lowest-numbered iteration whose entry is invalid, if any such iteration exists. That iteration becomes k.
- R7: When no iteration matches and every entry is valid, the victim is the iteration with the smallest use count. Among equal counts the lowest-numbered iteration wins.
- R8: busy is 0 after reset and while idle. While idle, no update or write request is issued. A start that arrives while busy is ignored: it neither changes the walk in progress nor causes another walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Retirement request, accepted when idle |
| rt_pc | input | PC_W | Real PC of the retired indirect branch |
| rt_hist | input | HIST_W | Global history captured at prediction time |
| rt_tgt | input | PC_W | Resolved target |
| rt_iter | input | ITER_W | Iteration that produced the prediction |
| rt_hit | input | 1 | 1 if the prediction was correct |
| busy | output | 1 | Walk in progress |
| buf_rd_en | output | 1 | Target-buffer read request |
| buf_rd_addr | output | PC_W | Virtual PC to read |
| buf_rd_valid | input | 1 | Read entry valid |
| buf_rd_tgt | input | PC_W | Read entry target |
| buf_rd_cnt | input | CNT_W | Read entry use count |
| dp_upd_valid | output | 1 | Direction-predictor update request |
| dp_upd_pc | output | PC_W | Virtual PC of the update |
| dp_upd_hist | output | HIST_W | Virtual history of the update |
| dp_upd_taken | output | 1 | Training direction |
| buf_wr_en | output | 1 | Target-buffer write request |
| buf_wr_addr | output | PC_W | Virtual PC to write |
| buf_wr_tgt | output | PC_W | Target to store |
| buf_wr_cnt | output | CNT_W | Use count to store |

## Verification
The bench aims at the edges of the chain: a match at iteration 0, a match at the last iteration, and a request with no match at all. A design with an off-by-one walk would train one virtual branch too few or too many, or would mark the wrong branch taken. Victim choice is checked in three ways: an invalid entry is placed after a valid entry with count 0, all counts are equal, and the lowest count appears twice. A wrong priority or tie-break would install the target over the wrong iteration. A count already at its maximum exposes counters that wrap. A start pulse held high during a walk exposes a design that restarts or re-latches its inputs while busy.

// File: rtl/vbr_pkg.sv
package vbr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_TRAIN = 2'd2
    } vbr_state_e;

    localparam logic [63:0] VBR_HASH_K = 64'h9E3779B97F4A7C15;

    // Per-iteration hash product; callers keep the low bits they need.
    function automatic logic [63:0] vbr_hash(input logic [7:0] iter);
        return {56'd0, iter} * VBR_HASH_K;
    endfunction

endpackage

// File: rtl/vbr_vaddr.sv
module vbr_vaddr #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 16,
    parameter int ITER_W = 2
) (
    input  logic [PC_W-1:0]   base_pc,
    input  logic [HIST_W-1:0] base_hist,
    input  logic [ITER_W-1:0] iter,
    output logic [PC_W-1:0]   vpc,
    output logic [HIST_W-1:0] vhist
);
    import vbr_pkg::*;

    logic [63:0] prod;

    always_comb begin
        prod  = vbr_hash(8'(iter));
        vpc   = base_pc ^ prod[PC_W-1:0];
        vhist = base_hist << iter;
    end

endmodule

// File: rtl/vbr_victim.sv
module vbr_victim #(
    parameter int ITER_W = 2,
    parameter int CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sample,
    input  logic              first,
    input  logic [ITER_W-1:0] cur_idx,
    input  logic              cur_valid,
    input  logic [CNT_W-1:0]  cur_cnt,
    output logic [ITER_W-1:0] sel_idx
);
    logic [ITER_W-1:0] best_idx;
    logic              best_empty;
    logic [CNT_W-1:0]  best_cnt;
    logic              better;

    // An empty slot beats any filled one, then a strictly lower count wins.
    always_comb begin
        if (first)
            better = 1'b1;
        else if (best_empty)
            better = 1'b0;
        else if (!cur_valid)
            better = 1'b1;
        else
            better = (cur_cnt < best_cnt);
        sel_idx = better ? cur_idx : best_idx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            best_idx   <= '0;
            best_empty <= 1'b0;
            best_cnt   <= '0;
        end else if (sample && better) begin
            best_idx   <= cur_idx;
            best_empty <= !cur_valid;
            best_cnt   <= cur_cnt;
        end
    end

endmodule

// File: rtl/vbr_trainer.sv
module vbr_trainer #(
    parameter int PC_W     = 32,
    parameter int HIST_W   = 16,
    parameter int MAX_ITER = 4,
    parameter int CNT_W    = 2,
    localparam int ITER_W  = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [PC_W-1:0]   rt_pc,
    input  logic [HIST_W-1:0] rt_hist,
    input  logic [PC_W-1:0]   rt_tgt,
    input  logic [ITER_W-1:0] rt_iter,
    input  logic              rt_hit,
    output logic              busy,
    output logic              buf_rd_en,
    output logic [PC_W-1:0]   buf_rd_addr,
    input  logic              buf_rd_valid,
    input  logic [PC_W-1:0]   buf_rd_tgt,
    input  logic [CNT_W-1:0]  buf_rd_cnt,
    output logic              dp_upd_valid,
    output logic [PC_W-1:0]   dp_upd_pc,
    output logic [HIST_W-1:0] dp_upd_hist,
    output logic              dp_upd_taken,
    output logic              buf_wr_en,
    output logic [PC_W-1:0]   buf_wr_addr,
    output logic [PC_W-1:0]   buf_wr_tgt,
    output logic [CNT_W-1:0]  buf_wr_cnt
);
    import vbr_pkg::*;

    localparam logic [ITER_W-1:0] LAST_ITER = ITER_W'(MAX_ITER - 1);
    localparam logic [CNT_W-1:0]  CNT_MAX   = '1;
    localparam logic [CNT_W-1:0]  CNT_NEW   = CNT_W'(1);

    vbr_state_e        state_q;
    logic [ITER_W-1:0] iter_q;
    logic [ITER_W-1:0] final_q;
    logic              insert_q;
    logic [PC_W-1:0]   pc_q;
    logic [HIST_W-1:0] hist_q;
    logic [PC_W-1:0]   tgt_q;

    logic [PC_W-1:0]   vpc;
    logic [HIST_W-1:0] vhist;
    logic [ITER_W-1:0] victim_idx;
    logic              scanning;
    logic              match;
    logic              at_final;

    vbr_vaddr #(.PC_W(PC_W), .HIST_W(HIST_W), .ITER_W(ITER_W)) u_vaddr (
        .base_pc   (pc_q),
        .base_hist (hist_q),
        .iter      (iter_q),
        .vpc       (vpc),
        .vhist     (vhist)
    );

    vbr_victim #(.ITER_W(ITER_W), .CNT_W(CNT_W)) u_victim (
        .clk       (clk),
        .rst       (rst),
        .sample    (scanning),
        .first     (iter_q == '0),
        .cur_idx   (iter_q),
        .cur_valid (buf_rd_valid),
        .cur_cnt   (buf_rd_cnt),
        .sel_idx   (victim_idx)
    );

    always_comb begin
        scanning     = (state_q == ST_SCAN);
        match        = buf_rd_valid && (buf_rd_tgt == tgt_q);
        at_final     = (state_q == ST_TRAIN) && (iter_q == final_q);
        busy         = (state_q != ST_IDLE);
        buf_rd_en    = busy;
        buf_rd_addr  = vpc;
        dp_upd_valid = (state_q == ST_TRAIN);
        dp_upd_pc    = vpc;
        dp_upd_hist  = vhist;
        dp_upd_taken = at_final;
        buf_wr_en    = at_final;
        buf_wr_addr  = vpc;
        buf_wr_tgt   = tgt_q;
        if (insert_q)
            buf_wr_cnt = CNT_NEW;
        else if (buf_rd_cnt == CNT_MAX)
            buf_wr_cnt = CNT_MAX;
        else
            buf_wr_cnt = buf_rd_cnt + CNT_NEW;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            iter_q   <= '0;
            final_q  <= '0;
            insert_q <= 1'b0;
            pc_q     <= '0;
            hist_q   <= '0;
            tgt_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        pc_q     <= rt_pc;
                        hist_q   <= rt_hist;
                        tgt_q    <= rt_tgt;
                        iter_q   <= '0;
                        insert_q <= 1'b0;
                        final_q  <= rt_iter;
                        state_q  <= rt_hit ? ST_TRAIN : ST_SCAN;
                    end
                end
                ST_SCAN: begin
                    if (match) begin
                        final_q <= iter_q;
                        iter_q  <= '0;
                        state_q <= ST_TRAIN;
                    end else if (iter_q == LAST_ITER) begin
                        final_q  <= victim_idx;
                        insert_q <= 1'b1;
                        iter_q   <= '0;
                        state_q  <= ST_TRAIN;
                    end else begin
                        iter_q <= iter_q + 1'b1;
                    end
                end
                ST_TRAIN: begin
                    if (iter_q == final_q)
                        state_q <= ST_IDLE;
                    else
                        iter_q <= iter_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/vbr_trainer_chk.sv
module vbr_trainer_chk #(
    parameter int PC_W   = 32,
    parameter int HIST_W = 16,
    parameter int CNT_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              busy,
    input logic              dp_upd_valid,
    input logic [HIST_W-1:0] dp_upd_hist,
    input logic              dp_upd_taken,
    input logic              buf_wr_en,
    input logic [PC_W-1:0]   buf_wr_addr,
    input logic [PC_W-1:0]   dp_upd_pc,
    input logic [CNT_W-1:0]  buf_wr_cnt
);
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (rst)
        dp_upd_valid && $past(dp_upd_valid) && !$past(rst) |-> dp_upd_hist == ($past(dp_upd_hist) << 1)); // R1
    AST_TAKEN_ENDS: assert property (@(posedge clk) disable iff (rst)
        dp_upd_valid && dp_upd_taken |=> !busy); // R2
    AST_NOTTAKEN_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        dp_upd_valid && !dp_upd_taken |-> !buf_wr_en); // R2
    AST_WRITE_SAME_VPC: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> dp_upd_valid && dp_upd_taken && buf_wr_addr == dp_upd_pc); // R2
    AST_CNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        buf_wr_en |-> buf_wr_cnt != '0); // R5
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !dp_upd_valid && !buf_wr_en); // R8
endmodule

bind vbr_trainer vbr_trainer_chk #(.PC_W(PC_W), .HIST_W(HIST_W), .CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .busy         (busy),
    .dp_upd_valid (dp_upd_valid),
    .dp_upd_hist  (dp_upd_hist),
    .dp_upd_taken (dp_upd_taken),
    .buf_wr_en    (buf_wr_en),
    .buf_wr_addr  (buf_wr_addr),
    .dp_upd_pc    (dp_upd_pc),
    .buf_wr_cnt   (buf_wr_cnt)
);

// File: tb/vbr_trainer_tb.sv
module vbr_trainer_tb;

    typedef struct packed {
        logic       hit;
        logic [1:0] piter;
        logic [3:0] vmask;
        logic [7:0] cnts;
        logic [2:0] midx;
        logic [1:0] ek;
        logic       eins;
        logic [1:0] ecnt;
    } vec_t;

    localparam int NV = 9;
    // hit piter vmask cnts(i3..i0) midx(4=none) k ins cnt
    localparam vec_t VECS [NV] = '{
        '{1'b1, 2'd2, 4'hF, 8'b00_01_11_11, 3'd2, 2'd2, 1'b0, 2'd2},  // R3
        '{1'b0, 2'd0, 4'hF, 8'b00_00_11_00, 3'd1, 2'd1, 1'b0, 2'd3},  // R4 R5
        '{1'b0, 2'd0, 4'hF, 8'b01_10_01_11, 3'd4, 2'd1, 1'b1, 2'd1},  // R7 tie
        '{1'b0, 2'd0, 4'hB, 8'b00_00_00_00, 3'd4, 2'd2, 1'b1, 2'd1},  // R6
        '{1'b0, 2'd0, 4'hF, 8'b00_00_00_01, 3'd0, 2'd0, 1'b0, 2'd2},  // R4 first
        '{1'b0, 2'd0, 4'hF, 8'b00_10_10_10, 3'd3, 2'd3, 1'b0, 2'd1},  // R4 last
        '{1'b1, 2'd0, 4'hF, 8'b00_00_00_10, 3'd0, 2'd0, 1'b0, 2'd3},  // R3
        '{1'b0, 2'd0, 4'hF, 8'b10_10_10_10, 3'd4, 2'd0, 1'b1, 2'd1},  // R7 all equal
        '{1'b0, 2'd0, 4'h0, 8'b11_11_11_11, 3'd4, 2'd0, 1'b1, 2'd1}   // R6 all empty
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] rt_pc = '0;
    logic [15:0] rt_hist = '0;
    logic [31:0] rt_tgt = '0;
    logic [1:0]  rt_iter = '0;
    logic        rt_hit = 1'b0;
    logic        busy, buf_rd_en, buf_rd_valid;
    logic [31:0] buf_rd_addr, buf_rd_tgt;
    logic [1:0]  buf_rd_cnt;
    logic        dp_upd_valid, dp_upd_taken, buf_wr_en;
    logic [31:0] dp_upd_pc, buf_wr_addr, buf_wr_tgt;
    logic [15:0] dp_upd_hist;
    logic [1:0]  buf_wr_cnt;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    // buffer contents for the current scenario
    logic [31:0] m_pc, m_tgt;
    logic [3:0]  m_vmask;
    logic [7:0]  m_cnts;
    logic [2:0]  m_midx;

    always #2.5 clk = ~clk;

    vbr_trainer u_dut (
        .clk(clk), .rst(rst), .start(start), .rt_pc(rt_pc), .rt_hist(rt_hist),
        .rt_tgt(rt_tgt), .rt_iter(rt_iter), .rt_hit(rt_hit), .busy(busy),
        .buf_rd_en(buf_rd_en), .buf_rd_addr(buf_rd_addr), .buf_rd_valid(buf_rd_valid),
        .buf_rd_tgt(buf_rd_tgt), .buf_rd_cnt(buf_rd_cnt), .dp_upd_valid(dp_upd_valid),
        .dp_upd_pc(dp_upd_pc), .dp_upd_hist(dp_upd_hist), .dp_upd_taken(dp_upd_taken),
        .buf_wr_en(buf_wr_en), .buf_wr_addr(buf_wr_addr), .buf_wr_tgt(buf_wr_tgt),
        .buf_wr_cnt(buf_wr_cnt)
    );

    function automatic logic [31:0] exp_vpc(input logic [31:0] pc, input int i);
        logic [63:0] p;
        p = 64'(i) * 64'h9E3779B97F4A7C15;
        return pc ^ p[31:0];
    endfunction

    always @* begin
        buf_rd_valid = 1'b0;
        buf_rd_tgt   = '0;
        buf_rd_cnt   = '0;
        for (int i = 0; i < 4; i++) begin
            if (buf_rd_addr == exp_vpc(m_pc, i)) begin
                buf_rd_valid = m_vmask[i];
                buf_rd_tgt   = (3'(i) == m_midx) ? m_tgt : (m_tgt ^ (32'(i + 1) << 4));
                buf_rd_cnt   = m_cnts[2*i +: 2];
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

    // Runs one walk; optionally pulses start with other inputs while busy.
    task automatic run_walk(input vec_t v, input int s, input bit poke);
        logic [31:0] upc [8];
        logic [15:0] uhist [8];
        logic        utk [8];
        int          nupd = 0;
        int          nwr = 0;
        logic [31:0] wa = '0, wt = '0;
        logic [1:0]  wc = '0;
        logic [15:0] h;
        int          k;
        string       rq;
        m_pc = 32'h1000_0040 + 32'(s) * 32'h111;
        m_tgt = 32'h4000_0000 + 32'(s) * 4;
        m_vmask = v.vmask;
        m_cnts = v.cnts;
        m_midx = v.midx;
        h = 16'hA5C3 ^ 16'(s);
        @(negedge clk);
        rt_pc = m_pc; rt_hist = h; rt_tgt = m_tgt;
        rt_iter = v.piter; rt_hit = v.hit; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int c = 0; c < 40; c++) begin
            if (!busy) break;
            if (dp_upd_valid && nupd < 8) begin
                upc[nupd] = dp_upd_pc; uhist[nupd] = dp_upd_hist; utk[nupd] = dp_upd_taken;
                nupd++;
            end
            if (buf_wr_en) begin
                nwr++; wa = buf_wr_addr; wt = buf_wr_tgt; wc = buf_wr_cnt;
            end
            if (poke && c >= 1 && c <= 2) begin
                start = 1'b1; rt_pc = 32'hDEAD_0000; rt_tgt = 32'h0BAD_0000; rt_hit = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        k = int'(v.ek);
        rq = v.eins ? (v.vmask != 4'hF ? "R6" : "R7") : (v.hit ? "R3" : "R4");
        check(nupd == k + 1, "R2", "update count", 32'(nupd), 32'(k + 1));
        for (int i = 0; i < 8; i++) begin
            if (i < nupd && i <= k) begin
                check(upc[i] == exp_vpc(m_pc, i), "R1", "virtual pc", upc[i], exp_vpc(m_pc, i));
                check(uhist[i] == (h << i), "R1", "virtual history", 32'(uhist[i]), 32'(h << i));
                check(utk[i] == (i == k), "R2", "direction", 32'(utk[i]), 32'(i == k));
            end
        end
        check(nwr == 1, rq, "write count", 32'(nwr), 32'd1);
        check(wa == exp_vpc(m_pc, k), rq, "write slot", wa, exp_vpc(m_pc, k));
        check(wt == m_tgt, rq, "write target", wt, m_tgt);
        check(wc == v.ecnt, (v.ecnt == 2'd3 && !v.eins) ? "R5" : rq, "write count value",
              32'(wc), 32'(v.ecnt));
    endtask

    initial begin
        m_pc = '0; m_tgt = '0; m_vmask = '0; m_cnts = '0; m_midx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        check(busy == 1'b0, "R8", "busy after reset", 32'(busy), 32'd0);
        check(dp_upd_valid == 1'b0 && buf_wr_en == 1'b0, "R8", "idle requests",
              32'({dp_upd_valid, buf_wr_en}), 32'd0);

        for (int s = 0; s < NV; s++) run_walk(VECS[s], s, 1'b0);

        // R3: correct prediction starts training in the first cycle
        @(negedge clk);
        m_pc = 32'h2222_0000; m_tgt = 32'h3333_0000; m_vmask = 4'hF; m_cnts = 8'h00; m_midx = 3'd1;
        rt_pc = m_pc; rt_hist = 16'h0001; rt_tgt = m_tgt; rt_iter = 2'd1; rt_hit = 1'b1; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check(dp_upd_valid == 1'b1 && dp_upd_taken == 1'b0, "R3", "no scan before training",
              32'({dp_upd_valid, dp_upd_taken}), 32'd2);
        repeat (3) @(negedge clk);

        // R8: start held during a walk is ignored
        run_walk(VECS[5], 5, 1'b1);
        repeat (3) @(negedge clk);
        check(busy == 1'b0 && dp_upd_valid == 1'b0, "R8", "no walk after ignored start",
              32'({busy, dp_upd_valid}), 32'd0);

        finish_run();
    end

endmodule